// File: doc/BRIEF.md
# Register-Write Command Stream Executor

This block walks a list of 64-bit commands held in a dword-addressed command memory and turns them into writes on a display pipe's register bus. Software places the commands in memory and gives the executor a byte start pointer and a byte end pointer, both 64-byte aligned. A start pulse then launches it. The executor reads the commands in order. It issues single writes with per-byte enables and bursts of writes to one register whose length is counted by the command itself. It stalls on a count of microsecond ticks or vblank pulses, raises an interrupt pulse when asked to, and hands scanline-window waits to a neighbouring unit.

Execution is write-only: the register bus is never read. The executor stays busy until its command pointer equals the end pointer. A halt input stops it at once. An opcode it does not know is skipped and latches an error flag that the next accepted start clears.

Top module: `cmd_stream_exec`

## Requirements
- R1: After reset, busy, irq, err_opcode, reg_wr_en, win_start and mem_rd_en are all low.
- R2: A start seen while idle with head_addr different from tail_addr makes busy high on the next cycle. A start with equal pointers leaves busy low and still clears err_opcode.
- R3: A command whose upper dword has bits 31:24 equal to 0x01 produces exactly one register write. The write uses reg_wr_addr = upper[19:0], reg_wr_be = upper[23:20] (bit n enables byte lane n) and reg_wr_data = lower dword.
- R4: A command with opcode 0x09 has a lower dword holding a count N and upper[19:0] holding an offset. It writes the N dwords that follow it, in memory order, all to that offset with reg_wr_be = 4'hF. N = 0 writes nothing.
- R5: When N is odd, the zero pad dword after the burst is never read. The next command is fetched from the following 8-byte boundary.
- R6: Opcode 0x02 waits until as many us_tick pulses as its lower dword gives have been seen after the command is decoded. No memory read is issued during the wait. A count of 0 does not stall.
- R7: Opcode 0x04 waits in the same way on vblank_pulse.
- R8: Opcode 0x07 gives a single-cycle irq pulse. Opcode 0x00 does nothing, and neither of them writes.
- R9: Opcodes 0x05 (win_inside=1) and 0x06 (win_inside=0) give a one-cycle win_start with win_lo = lower[19:0] and win_hi = {upper[7:0], lower[31:20]}. Execution then stalls until win_done.
- R10: Any other opcode is skipped without a write, execution continues, and err_opcode goes high and stays high until the next accepted start.
- R11: Busy falls in the cycle after the last command before tail has been handled. A start seen while busy is ignored.
- R12: halt drives busy low on the next cycle, and no further write, irq or memory read follows until a new start.
- R13: Memory reads use dword addresses equal to the byte address divided by 4, beginning at head_addr/4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, accepted only while idle |
| halt | input | 1 | Abort execution |
| head_addr | input | ADDR_W | Byte address of the first command |
| tail_addr | input | ADDR_W | Byte address one past the last command |
| mem_rd_en | output | 1 | Command memory read strobe |
| mem_rd_addr | output | ADDR_W-2 | Dword address of the read |
| mem_rd_data | input | 32 | Read data, valid the cycle after the strobe |
| reg_wr_en | output | 1 | Register write strobe |
| reg_wr_addr | output | 20 | Register offset |
| reg_wr_data | output | 32 | Register write data |
| reg_wr_be | output | 4 | Byte-lane enables |
| us_tick | input | 1 | One-microsecond tick pulse |
| vblank_pulse | input | 1 | Single-cycle vblank pulse |
| win_start | output | 1 | Request to the scanline-window unit |
| win_inside | output | 1 | 1: wait until inside window, 0: until outside |
| win_lo | output | 20 | Lower scanline of the window |
| win_hi | output | 20 | Upper scanline of the window |
| win_done | input | 1 | Window condition met |
| busy | output | 1 | Executor running |
| irq | output | 1 | Interrupt pulse from an interrupt command |
| err_opcode | output | 1 | Sticky unknown-opcode flag |

## Verification
The hardest cases to reach are the stalls and the events that arrive during them: the last tick of a wait, a start that lands while busy, and a halt in the middle of a wait. The bench holds us_tick, vblank_pulse and win_done under direct control. It releases one pulse fewer than the count, checks that nothing has moved, and then releases the final one. Starts and halts are injected while the executor is known to be parked in a wait. The pad-skip case is covered by sweeping burst lengths 0 to 5. For odd lengths the bench watches that the pad address is never read and that the marker write after it still decodes correctly.

// File: rtl/cse_pkg.sv
package cse_pkg;

    localparam int REG_W = 20;

    localparam logic [7:0] OPC_NOP     = 8'h00;
    localparam logic [7:0] OPC_WRITE   = 8'h01;
    localparam logic [7:0] OPC_WAIT_US = 8'h02;
    localparam logic [7:0] OPC_WAIT_VB = 8'h04;
    localparam logic [7:0] OPC_WIN_IN  = 8'h05;
    localparam logic [7:0] OPC_WIN_OUT = 8'h06;
    localparam logic [7:0] OPC_IRQ     = 8'h07;
    localparam logic [7:0] OPC_BURST   = 8'h09;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_LO,
        S_RD_HI,
        S_EXEC,
        S_WAIT_US,
        S_WAIT_VB,
        S_WAIT_WIN,
        S_BURST_RD,
        S_BURST_WR
    } state_e;

    typedef enum logic [2:0] {
        K_NOP,
        K_WRITE,
        K_WAIT_US,
        K_WAIT_VB,
        K_WIN,
        K_IRQ,
        K_BURST,
        K_BAD
    } kind_e;

    typedef struct packed {
        kind_e            kind;
        logic [REG_W-1:0] reg_off;
        logic [3:0]       be;
        logic             win_in;
        logic [19:0]      win_lo;
        logic [19:0]      win_hi;
    } cmd_t;

endpackage

// File: rtl/cse_decode.sv
module cse_decode
    import cse_pkg::*;
(
    input  logic [31:0] lo_word,
    input  logic [31:0] hi_word,
    output cmd_t        cmd
);

    always_comb begin
        cmd.reg_off = hi_word[REG_W-1:0];
        cmd.be      = hi_word[23:20];
        cmd.win_in  = (hi_word[31:24] == OPC_WIN_IN);
        cmd.win_lo  = lo_word[19:0];
        cmd.win_hi  = {hi_word[7:0], lo_word[31:20]};
        unique case (hi_word[31:24])
            OPC_NOP:     cmd.kind = K_NOP;
            OPC_WRITE:   cmd.kind = K_WRITE;
            OPC_WAIT_US: cmd.kind = K_WAIT_US;
            OPC_WAIT_VB: cmd.kind = K_WAIT_VB;
            OPC_WIN_IN:  cmd.kind = K_WIN;
            OPC_WIN_OUT: cmd.kind = K_WIN;
            OPC_IRQ:     cmd.kind = K_IRQ;
            OPC_BURST:   cmd.kind = K_BURST;
            default:     cmd.kind = K_BAD;
        endcase
    end

endmodule

// File: rtl/cse_stall.sv
module cse_stall #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             idle
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (abort) begin
            cnt_d = '0;
        end else if (load) begin
            cnt_d = load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign idle = (cnt_q == '0);

    // R6 / R7: each pulse takes exactly one off the remaining count
    p_tick_decrements_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && !abort && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R6 / R7: a load arms the full count
    p_load_arms_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !abort) |=> (cnt_q == $past(load_val)));

    // R12: an abort empties the counter
    p_abort_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> idle);

endmodule

// File: rtl/cmd_stream_exec.sv
module cmd_stream_exec
    import cse_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              halt,
    input  logic [ADDR_W-1:0] head_addr,
    input  logic [ADDR_W-1:0] tail_addr,
    output logic              mem_rd_en,
    output logic [ADDR_W-3:0] mem_rd_addr,
    input  logic [31:0]       mem_rd_data,
    output logic              reg_wr_en,
    output logic [19:0]       reg_wr_addr,
    output logic [31:0]       reg_wr_data,
    output logic [3:0]        reg_wr_be,
    input  logic              us_tick,
    input  logic              vblank_pulse,
    output logic              win_start,
    output logic              win_inside,
    output logic [19:0]       win_lo,
    output logic [19:0]       win_hi,
    input  logic              win_done,
    output logic              busy,
    output logic              irq,
    output logic              err_opcode
);

    localparam int PTR_W = ADDR_W - 2;

    typedef struct packed {
        state_e           st;
        logic [PTR_W-1:0] ptr;
        logic [PTR_W-1:0] tail;
        logic [31:0]      lo;
        logic [REG_W-1:0] burst_off;
        logic [31:0]      burst_left;
        logic             wr_en;
        logic [REG_W-1:0] wr_addr;
        logic [31:0]      wr_data;
        logic [3:0]       wr_be;
        logic             irq;
        logic             err;
        logic             win_start;
        logic             win_in;
        logic [19:0]      win_lo;
        logic [19:0]      win_hi;
    } seq_t;

    seq_t s_d, s_q;
    cmd_t cmd;
    logic us_load, vb_load, us_idle, vb_idle;
    logic [PTR_W-1:0] head_dw, tail_dw;
    logic [PTR_W-1:0] after_burst;

    assign head_dw = head_addr[ADDR_W-1:2];
    assign tail_dw = tail_addr[ADDR_W-1:2];

    cse_decode u_decode (
        .lo_word (s_q.lo),
        .hi_word (mem_rd_data),
        .cmd     (cmd)
    );

    cse_stall #(.CNT_W(CNT_W)) u_us (
        .clk      (clk),
        .rst_n    (rst_n),
        .abort    (halt),
        .load     (us_load),
        .load_val (s_q.lo[CNT_W-1:0]),
        .tick     (us_tick),
        .idle     (us_idle)
    );

    cse_stall #(.CNT_W(CNT_W)) u_vb (
        .clk      (clk),
        .rst_n    (rst_n),
        .abort    (halt),
        .load     (vb_load),
        .load_val (s_q.lo[CNT_W-1:0]),
        .tick     (vblank_pulse),
        .idle     (vb_idle)
    );

    function automatic state_e step_to(input logic [PTR_W-1:0] p, input logic [PTR_W-1:0] t);
        return (p == t) ? S_IDLE : S_RD_LO;
    endfunction

    // last data word plus one, rounded up to an even dword
    always_comb begin
        after_burst = s_q.ptr + PTR_W'(1);
        if (after_burst[0]) begin
            after_burst = after_burst + PTR_W'(1);
        end
    end

    always_comb begin
        s_d           = s_q;
        s_d.wr_en     = 1'b0;
        s_d.irq       = 1'b0;
        s_d.win_start = 1'b0;
        us_load       = 1'b0;
        vb_load       = 1'b0;

        unique case (s_q.st)
            S_IDLE: begin
                if (start) begin
                    s_d.ptr  = head_dw;
                    s_d.tail = tail_dw;
                    s_d.err  = 1'b0;
                    s_d.st   = step_to(head_dw, tail_dw);
                end
            end
            S_RD_LO: begin
                s_d.st = S_RD_HI;
            end
            S_RD_HI: begin
                s_d.lo = mem_rd_data;
                s_d.st = S_EXEC;
            end
            S_EXEC: begin
                s_d.ptr = s_q.ptr + PTR_W'(2);
                s_d.st  = step_to(s_q.ptr + PTR_W'(2), s_q.tail);
                unique case (cmd.kind)
                    K_NOP: begin
                    end
                    K_WRITE: begin
                        s_d.wr_en   = 1'b1;
                        s_d.wr_addr = cmd.reg_off;
                        s_d.wr_data = s_q.lo;
                        s_d.wr_be   = cmd.be;
                    end
                    K_WAIT_US: begin
                        if (s_q.lo[CNT_W-1:0] != '0) begin
                            us_load = 1'b1;
                            s_d.st  = S_WAIT_US;
                        end
                    end
                    K_WAIT_VB: begin
                        if (s_q.lo[CNT_W-1:0] != '0) begin
                            vb_load = 1'b1;
                            s_d.st  = S_WAIT_VB;
                        end
                    end
                    K_WIN: begin
                        s_d.win_start = 1'b1;
                        s_d.win_in    = cmd.win_in;
                        s_d.win_lo    = cmd.win_lo;
                        s_d.win_hi    = cmd.win_hi;
                        s_d.st        = S_WAIT_WIN;
                    end
                    K_IRQ: begin
                        s_d.irq = 1'b1;
                    end
                    K_BURST: begin
                        s_d.burst_off  = cmd.reg_off;
                        s_d.burst_left = s_q.lo;
                        if (s_q.lo != '0) begin
                            s_d.st = S_BURST_RD;
                        end
                    end
                    default: begin
                        s_d.err = 1'b1;
                    end
                endcase
            end
            S_WAIT_US: begin
                if (us_idle) begin
                    s_d.st = step_to(s_q.ptr, s_q.tail);
                end
            end
            S_WAIT_VB: begin
                if (vb_idle) begin
                    s_d.st = step_to(s_q.ptr, s_q.tail);
                end
            end
            S_WAIT_WIN: begin
                if (win_done) begin
                    s_d.st = step_to(s_q.ptr, s_q.tail);
                end
            end
            S_BURST_RD: begin
                s_d.st = S_BURST_WR;
            end
            S_BURST_WR: begin
                s_d.wr_en      = 1'b1;
                s_d.wr_addr    = s_q.burst_off;
                s_d.wr_data    = mem_rd_data;
                s_d.wr_be      = 4'hF;
                s_d.burst_left = s_q.burst_left - 32'd1;
                if (s_q.burst_left == 32'd1) begin
                    s_d.ptr = after_burst;
                    s_d.st  = step_to(after_burst, s_q.tail);
                end else begin
                    s_d.ptr = s_q.ptr + PTR_W'(1);
                    s_d.st  = S_BURST_RD;
                end
            end
            default: begin
                s_d.st = S_IDLE;
            end
        endcase

        if (halt) begin
            s_d.st        = S_IDLE;
            s_d.wr_en     = 1'b0;
            s_d.irq       = 1'b0;
            s_d.win_start = 1'b0;
            us_load       = 1'b0;
            vb_load       = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: S_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_rd_en   = (s_q.st == S_RD_LO) || (s_q.st == S_RD_HI) || (s_q.st == S_BURST_RD);
    assign mem_rd_addr = (s_q.st == S_RD_HI) ? (s_q.ptr + PTR_W'(1)) : s_q.ptr;
    assign reg_wr_en   = s_q.wr_en;
    assign reg_wr_addr = s_q.wr_addr;
    assign reg_wr_data = s_q.wr_data;
    assign reg_wr_be   = s_q.wr_be;
    assign win_start   = s_q.win_start;
    assign win_inside  = s_q.win_in;
    assign win_lo      = s_q.win_lo;
    assign win_hi      = s_q.win_hi;
    assign busy        = (s_q.st != S_IDLE);
    assign irq         = s_q.irq;
    assign err_opcode  = s_q.err;

    p_start_runs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !halt && (head_dw != tail_dw)) |=> busy);

    p_empty_stays_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && (head_dw == tail_dw)) |=> (!busy && !err_opcode));

    p_write_from_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> $past(busy));

    p_stall_no_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.st == S_WAIT_US) || (s_q.st == S_WAIT_VB)) |-> !mem_rd_en);

    p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_win_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        win_start |=> (!win_start && busy));

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_opcode && !(start && !busy)) |=> err_opcode);

    p_halt_stops_r12: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (!busy && !reg_wr_en && !irq && !win_start && !mem_rd_en));

endmodule

// File: tb/sim_cmd_stream_exec.sv
module sim_cmd_stream_exec;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        halt = 1'b0;
    logic [15:0] head_addr = '0;
    logic [15:0] tail_addr = '0;
    logic        mem_rd_en;
    logic [13:0] mem_rd_addr;
    logic [31:0] mem_rd_data = '0;
    logic        reg_wr_en;
    logic [19:0] reg_wr_addr;
    logic [31:0] reg_wr_data;
    logic [3:0]  reg_wr_be;
    logic        us_tick = 1'b0;
    logic        vblank_pulse = 1'b0;
    logic        win_start;
    logic        win_inside;
    logic [19:0] win_lo;
    logic [19:0] win_hi;
    logic        win_done = 1'b0;
    logic        busy;
    logic        irq;
    logic        err_opcode;

    always #4 clk = ~clk;

    cmd_stream_exec u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .halt(halt),
        .head_addr(head_addr), .tail_addr(tail_addr),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_wr_be(reg_wr_be), .us_tick(us_tick), .vblank_pulse(vblank_pulse),
        .win_start(win_start), .win_inside(win_inside), .win_lo(win_lo), .win_hi(win_hi),
        .win_done(win_done), .busy(busy), .irq(irq), .err_opcode(err_opcode)
    );

    logic [31:0] mem [0:255];
    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[7:0]];
    end

    int          errors = 0;
    int          checks = 0;
    int          wr_n = 0;
    logic [19:0] wr_a [0:63];
    logic [31:0] wr_v [0:63];
    logic [3:0]  wr_b [0:63];
    int          irq_n = 0;
    int          win_n = 0;
    int          rd_n = 0;
    logic [13:0] first_rd = '0;
    int          watch_addr = -1;
    int          watch_hits = 0;

    always @(negedge clk) begin
        if (reg_wr_en && wr_n < 64) begin
            wr_a[wr_n] = reg_wr_addr;
            wr_v[wr_n] = reg_wr_data;
            wr_b[wr_n] = reg_wr_be;
            wr_n = wr_n + 1;
        end
        if (irq) irq_n = irq_n + 1;
        if (win_start) win_n = win_n + 1;
        if (mem_rd_en) begin
            if (rd_n == 0) first_rd = mem_rd_addr;
            rd_n = rd_n + 1;
            if (int'(mem_rd_addr) == watch_addr) watch_hits = watch_hits + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic clear_all();
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        wr_n = 0; irq_n = 0; win_n = 0; rd_n = 0; watch_addr = -1; watch_hits = 0;
    endtask

    task automatic put(input int dw, input logic [31:0] lo, input logic [31:0] hi);
        mem[dw] = lo;
        mem[dw+1] = hi;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic launch(input logic [15:0] h, input logic [15:0] t);
        @(negedge clk); #1;
        head_addr = h; tail_addr = t; start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
    endtask

    task automatic finish_run(input int limit);
        for (int i = 0; i < limit && busy; i++) cyc(1);
        cyc(2);
    endtask

    task automatic pulse_us();
        @(negedge clk); #1 us_tick = 1'b1;
        @(negedge clk); #1 us_tick = 1'b0;
        cyc(1);
    endtask

    task automatic pulse_vb();
        @(negedge clk); #1 vblank_pulse = 1'b1;
        @(negedge clk); #1 vblank_pulse = 1'b0;
        cyc(1);
    endtask

    function automatic logic [31:0] wr_hi(input logic [3:0] be, input logic [19:0] off);
        return {8'h01, be, off};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks = checks + 1;
        errors = errors + 1;
        $display("FAIL R11 watchdog expired actual=%0d expected=0", 1);
        report();
        $finish;
    end

    initial begin
        clear_all();
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R1 reset state
        chk(!busy && !irq && !err_opcode, "R1 status idle", {busy, irq, err_opcode}, 0);
        chk(!reg_wr_en && !win_start && !mem_rd_en, "R1 ports quiet", {reg_wr_en, win_start, mem_rd_en}, 0);

        // R3/R13: byte-enable sweep from head 0x40
        clear_all();
        for (int i = 0; i < 16; i++)
            put(16 + 2*i, 32'hA500_0000 + i, wr_hi(4'(i), 20'h00100 + 20'(i*4)));
        launch(16'h0040, 16'h00C0);
        chk(busy == 1'b1, "R2 busy after start", busy, 1);
        finish_run(500);
        chk(first_rd == 14'd16, "R13 first read address", first_rd, 16);
        chk(wr_n == 16, "R3 write count", wr_n, 16);
        for (int i = 0; i < 16; i++) begin
            chk(wr_b[i] == 4'(i), "R3 byte enable", wr_b[i], i);
            chk(wr_a[i] == 20'h00100 + 20'(i*4), "R3 address", wr_a[i], 20'h00100 + i*4);
            chk(wr_v[i] == 32'hA500_0000 + i, "R3 data", wr_v[i], 32'hA500_0000 + i);
        end
        chk(!busy, "R11 busy falls at tail", busy, 0);

        // R4/R5: burst lengths 0..5
        for (int n = 0; n < 6; n++) begin
            int nxt;
            clear_all();
            put(0, 32'(n), {8'h09, 4'h0, 20'h02345});
            for (int k = 0; k < n; k++) mem[2+k] = 32'(n*256 + k + 1);
            nxt = 2 + n + (n % 2);
            if (n % 2 == 1) watch_addr = 2 + n;
            put(nxt, 32'(n), wr_hi(4'hF, 20'h00777));
            launch(16'h0000, 16'h0040);
            finish_run(500);
            chk(wr_n == n + 1, "R4 burst write count", wr_n, n + 1);
            for (int k = 0; k < n; k++) begin
                chk(wr_a[k] == 20'h02345 && wr_b[k] == 4'hF, "R4 burst offset/enables", {wr_a[k], wr_b[k]}, {20'h02345, 4'hF});
                chk(wr_v[k] == 32'(n*256 + k + 1), "R4 burst data order", wr_v[k], n*256 + k + 1);
            end
            chk(wr_a[n] == 20'h00777 && wr_v[n] == 32'(n), "R5 command after burst", wr_v[n], n);
            chk(watch_hits == 0, "R5 pad not read", watch_hits, 0);
        end

        // R6: microsecond wait of 4, then of 0
        clear_all();
        put(0, 32'h11, wr_hi(4'hF, 20'h00010));
        put(2, 32'd4, 32'h0200_0000);
        put(4, 32'h22, wr_hi(4'hF, 20'h00020));
        launch(16'h0000, 16'h0040);
        cyc(20);
        chk(wr_n == 1 && busy, "R6 stalled before ticks", wr_n, 1);
        rd_n = 0;
        for (int i = 0; i < 3; i++) pulse_us();
        cyc(10);
        chk(wr_n == 1, "R6 still stalled after count-1 ticks", wr_n, 1);
        chk(rd_n == 0, "R6 no fetch during wait", rd_n, 0);
        pulse_us();
        finish_run(200);
        chk(wr_n == 2 && wr_v[1] == 32'h22, "R6 resumes after last tick", wr_v[1], 32'h22);
        mem[2] = 32'd0;
        wr_n = 0;
        launch(16'h0000, 16'h0040);
        finish_run(200);
        chk(wr_n == 2, "R6 zero count does not stall", wr_n, 2);

        // R7: vblank wait of 2
        clear_all();
        put(0, 32'h33, wr_hi(4'hF, 20'h00030));
        put(2, 32'd2, 32'h0400_0000);
        put(4, 32'h44, wr_hi(4'hF, 20'h00040));
        launch(16'h0000, 16'h0040);
        cyc(20);
        pulse_vb();
        cyc(10);
        chk(wr_n == 1 && busy, "R7 held after one vblank", wr_n, 1);
        pulse_vb();
        finish_run(200);
        chk(wr_n == 2 && wr_v[1] == 32'h44, "R7 resumes after count vblanks", wr_n, 2);

        // R8: no-op and interrupt
        clear_all();
        put(0, 32'hDEAD, 32'h0000_0000);
        put(2, 32'h0, 32'h0700_0000);
        put(4, 32'h55, wr_hi(4'h3, 20'h00050));
        launch(16'h0000, 16'h0040);
        finish_run(200);
        chk(irq_n == 1, "R8 one irq pulse", irq_n, 1);
        chk(wr_n == 1 && wr_b[0] == 4'h3, "R8 nop and irq do not write", wr_n, 1);

        // R9: inside then outside window waits
        for (int m = 0; m < 2; m++) begin
            clear_all();
            put(0, 32'h4560_0123, {(m == 0) ? 8'h05 : 8'h06, 16'h0, 8'hAB});
            put(2, 32'h66, wr_hi(4'hF, 20'h00060));
            launch(16'h0000, 16'h0040);
            cyc(12);
            chk(win_n == 1, "R9 one window request", win_n, 1);
            chk(win_inside == (m == 0), "R9 window sense", win_inside, m == 0);
            chk(win_lo == 20'h00123 && win_hi == 20'hAB456, "R9 window bounds", win_hi, 20'hAB456);
            chk(wr_n == 0 && busy, "R9 stalled until done", wr_n, 0);
            @(negedge clk); #1 win_done = 1'b1;
            @(negedge clk); #1 win_done = 1'b0;
            finish_run(200);
            chk(wr_n == 1, "R9 resumes after done", wr_n, 1);
        end

        // R10: unknown opcode, then clear by an empty start (R2)
        clear_all();
        put(0, 32'h77, 32'h0300_0000);
        put(2, 32'h88, wr_hi(4'hF, 20'h00080));
        launch(16'h0000, 16'h0040);
        finish_run(200);
        chk(err_opcode == 1'b1, "R10 error flag set", err_opcode, 1);
        chk(wr_n == 1 && wr_v[0] == 32'h88, "R10 skipped and continued", wr_v[0], 32'h88);
        cyc(5);
        chk(err_opcode == 1'b1, "R10 error flag sticky", err_opcode, 1);
        launch(16'h0080, 16'h0080);
        chk(!busy, "R2 equal pointers stay idle", busy, 0);
        chk(!err_opcode, "R2 start clears error", err_opcode, 1'b0);

        // R11: start during a stall is ignored
        clear_all();
        put(0, 32'h11, wr_hi(4'hF, 20'h00010));
        put(2, 32'd1, 32'h0200_0000);
        put(4, 32'h22, wr_hi(4'hF, 20'h00020));
        put(32, 32'h99, wr_hi(4'hF, 20'h00099));
        launch(16'h0000, 16'h0040);
        cyc(15);
        launch(16'h0080, 16'h00C0);
        cyc(5);
        pulse_us();
        finish_run(200);
        chk(wr_n == 2 && wr_a[1] == 20'h00020, "R11 start while busy ignored", wr_n, 2);

        // R12: halt during a wait
        clear_all();
        put(0, 32'h11, wr_hi(4'hF, 20'h00010));
        put(2, 32'd5, 32'h0200_0000);
        put(4, 32'h22, wr_hi(4'hF, 20'h00020));
        launch(16'h0000, 16'h0040);
        cyc(15);
        @(negedge clk); #1 halt = 1'b1;
        @(negedge clk); #1 halt = 1'b0;
        chk(!busy, "R12 busy drops after halt", busy, 0);
        rd_n = 0;
        for (int i = 0; i < 8; i++) pulse_us();
        cyc(10);
        chk(wr_n == 1 && rd_n == 0, "R12 nothing after halt", wr_n, 1);

        report();
        $finish;
    end

endmodule